// File: doc/BRIEF.md
# Lockable-Way Round-Robin Cache Directory

This block is the tag directory of a set-associative cache whose lines can be pinned so that they behave as fast on-chip RAM. Each request carries a byte address and an operation: a plain lookup, a lock, or an unlock. The directory splits the address into tag, set index and line offset. It compares the tag against every way of the indexed set and, one clock later, reports whether the line hit and which way holds it.

On a lookup or lock miss, a victim way is chosen by a round-robin pointer kept per set. The search starts at the pointer, runs upward in way order and passes over pinned ways. The directory writes the new tag into that way and reports the set, way and tag, so that an external data array can be refilled. Because the pointer keeps rotating, every unpinned line leaves the cache sooner or later, while a pinned line stays resident and always hits.

A global invalidate discards every unpinned line in one cycle. The data array, the refill path, write-back and coherence are handled outside this block.

Top module: `lrc_dir`

## Requirements
- R1: A byte address is split as line offset bits [4:0], set index bits [9:5] and tag bits [31:10]. Addresses 1024 bytes apart therefore share a set, and a 64-byte aligned object covers two neighbouring sets.
- R2: A request sampled at a clock edge produces its response on the outputs right after that same edge. The response holds `rsp_valid`=1 and at most one of `rsp_hit`, `rsp_alloc` and `rsp_no_victim`. On a hit, `rsp_way` is the matching way.
- R3: A lookup miss allocates a way. The response gives `rsp_alloc`=1, `rsp_set`, `rsp_way` and `rsp_tag`, and a repeated lookup of that address then hits in that way.
- R4: The per-set pointer starts at way 0 and moves only when that set allocates. It moves to the way after the victim, wrapping from way 31 to way 0. Hits leave it unchanged.
- R5: The victim is the first unlocked way at or above the pointer, wrapping around. Locked ways are never chosen, so round robin eventually evicts every unlocked line.
- R6: A lock request (`req_op`=1) that misses allocates the line already locked. A lock request that hits sets the lock bit of the existing way, and the response gives `rsp_hit`=1 and `rsp_alloc`=0. A locked line is always valid.
- R7: An unlock request (`req_op`=2) that hits clears the lock bit. The line stays valid and becomes eligible for eviction. An unlock that misses changes nothing and reports no hit, allocation or no-victim.
- R8: If all 32 ways of the set are locked, a lookup or lock miss allocates nothing, raises `rsp_no_victim` and leaves the directory unchanged.
- R9: `inv_all` clears the valid bit of every unlocked line, and locked lines keep hitting. A request presented in the same cycle as `inv_all` is dropped, so the next cycle shows `rsp_valid`=0.
- R10: Reset leaves every line invalid and unlocked, every pointer at way 0, and all response outputs at zero.
- R11: The reserved operation code `req_op`=3 produces no response and does not change the directory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lookup, 1 lock, 2 unlock, 3 reserved |
| req_addr | input | 32 | Byte address of the request |
| inv_all | input | 1 | Invalidate all unlocked lines |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Address was present |
| rsp_alloc | output | 1 | A way was (re)filled with the request tag |
| rsp_no_victim | output | 1 | Miss with every way of the set locked |
| rsp_set | output | 5 | Set index of the request |
| rsp_way | output | 5 | Hit way or allocated way |
| rsp_tag | output | 22 | Tag of the request |

## Verification
The bench builds the directory with its default geometry of 32 ways, 32 sets and 32-byte lines. At that size, the whole set can be filled, so the pointer wrap from way 31 back to way 0 can be observed. Pinning all 32 ways of one set brings the no-victim case within reach in a few dozen requests. The same geometry shows the victim search stepping over locked ways after the wrap, and it shows invalidation sparing pinned lines while an unpinned line is refilled into the next way.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_RSVD   = 2'd3
    } lrc_op_e;

endpackage

// File: rtl/lrc_tag_match.sv
module lrc_tag_match #(
    parameter int WAYS  = 32,
    parameter int TAG_W = 22,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tags[w] == tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/lrc_victim_pick.sv
module lrc_victim_pick #(
    parameter int WAYS  = 32,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  lock_mask,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic [WAY_W-1:0] way
);

    always_comb begin
        logic [WAY_W-1:0] idx;
        found = 1'b0;
        way   = '0;
        for (int i = 0; i < WAYS; i++) begin
            idx = ptr + WAY_W'(i);
            if (!found && !lock_mask[idx]) begin
                found = 1'b1;
                way   = idx;
            end
        end
    end

endmodule

// File: rtl/lrc_dir.sv
module lrc_dir #(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 32,
    parameter int SETS       = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         req_valid,
    input  logic [1:0]                                   req_op,
    input  logic [ADDR_W-1:0]                            req_addr,
    input  logic                                         inv_all,
    output logic                                         rsp_valid,
    output logic                                         rsp_hit,
    output logic                                         rsp_alloc,
    output logic                                         rsp_no_victim,
    output logic [$clog2(SETS)-1:0]                      rsp_set,
    output logic [$clog2(WAYS)-1:0]                      rsp_way,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0] rsp_tag
);
    import lrc_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            lock;
        logic [SETS-1:0][WAY_W-1:0]           ptr;
        logic                                 rsp_valid;
        logic                                 rsp_hit;
        logic                                 rsp_alloc;
        logic                                 rsp_nov;
        logic [IDX_W-1:0]                     rsp_set;
        logic [WAY_W-1:0]                     rsp_way;
        logic [TAG_W-1:0]                     rsp_tag;
    } dir_state_t;

    dir_state_t st_d, st_q;

    logic [IDX_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] unused_off;
    lrc_op_e          op;

    assign req_set    = req_addr[OFF_W +: IDX_W];
    assign req_tag    = req_addr[OFF_W+IDX_W +: TAG_W];
    assign unused_off = req_addr[OFF_W-1:0];
    assign op         = lrc_op_e'(req_op);

    logic [WAYS-1:0]  hit_vec;
    logic             look_hit;
    logic [WAY_W-1:0] look_way;
    logic             vict_found;
    logic [WAY_W-1:0] vict_way;

    lrc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .set_valid (st_q.valid[req_set]),
        .set_tags  (st_q.tag[req_set]),
        .tag       (req_tag),
        .hit_vec   (hit_vec),
        .hit       (look_hit),
        .hit_way   (look_way)
    );

    lrc_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .lock_mask (st_q.lock[req_set]),
        .ptr       (st_q.ptr[req_set]),
        .found     (vict_found),
        .way       (vict_way)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_alloc = 1'b0;
        st_d.rsp_nov   = 1'b0;
        st_d.rsp_set   = '0;
        st_d.rsp_way   = '0;
        st_d.rsp_tag   = '0;

        if (inv_all) begin
            st_d.valid = st_q.valid & st_q.lock;
        end else if (req_valid && op != OP_RSVD) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_set   = req_set;
            st_d.rsp_tag   = req_tag;
            if (look_hit) begin
                st_d.rsp_hit = 1'b1;
                st_d.rsp_way = look_way;
                if (op == OP_LOCK) begin
                    st_d.lock[req_set][look_way] = 1'b1;
                end else if (op == OP_UNLOCK) begin
                    st_d.lock[req_set][look_way] = 1'b0;
                end
            end else if (op != OP_UNLOCK) begin
                if (vict_found) begin
                    st_d.rsp_alloc                = 1'b1;
                    st_d.rsp_way                  = vict_way;
                    st_d.tag[req_set][vict_way]   = req_tag;
                    st_d.valid[req_set][vict_way] = 1'b1;
                    st_d.lock[req_set][vict_way]  = (op == OP_LOCK);
                    st_d.ptr[req_set]             = vict_way + WAY_W'(1);
                end else begin
                    st_d.rsp_nov = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_hit       = st_q.rsp_hit;
    assign rsp_alloc     = st_q.rsp_alloc;
    assign rsp_no_victim = st_q.rsp_nov;
    assign rsp_set       = st_q.rsp_set;
    assign rsp_way       = st_q.rsp_way;
    assign rsp_tag       = st_q.rsp_tag;

endmodule

// File: rtl/lrc_dir_chk.sv
module lrc_dir_chk #(
    parameter int SETS  = 32,
    parameter int WAYS  = 32,
    parameter int IDX_W = 5,
    parameter int WAY_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       inv_all,
    input logic [SETS-1:0][WAYS-1:0]  lock_q,
    input logic [SETS-1:0][WAYS-1:0]  valid_q,
    input logic [WAYS-1:0]            hit_vec,
    input logic                       rsp_valid,
    input logic                       rsp_hit,
    input logic                       rsp_alloc,
    input logic                       rsp_no_victim,
    input logic [IDX_W-1:0]           rsp_set,
    input logic [WAY_W-1:0]           rsp_way
);

    logic [SETS-1:0][WAYS-1:0] prev_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lock <= '0;
        end else begin
            prev_lock <= lock_q;
        end
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_alloc, rsp_no_victim}) <= 1);

    // R2
    outcome_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_alloc || rsp_no_victim) |-> rsp_valid);

    // R5
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_alloc |-> !prev_lock[rsp_set][rsp_way]);

    // R3
    alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_alloc |-> valid_q[rsp_set][rsp_way]);

    // R8
    no_victim_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_no_victim |-> (&prev_lock[rsp_set]));

    // R6
    lock_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~valid_q) == '0);

    // R9
    inv_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !rsp_valid);

endmodule

bind lrc_dir lrc_dir_chk #(
    .SETS (SETS),
    .WAYS (WAYS),
    .IDX_W(IDX_W),
    .WAY_W(WAY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inv_all      (inv_all),
    .lock_q       (st_q.lock),
    .valid_q      (st_q.valid),
    .hit_vec      (hit_vec),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_alloc    (rsp_alloc),
    .rsp_no_victim(rsp_no_victim),
    .rsp_set      (rsp_set),
    .rsp_way      (rsp_way)
);

// File: tb/lrc_dir_bench.sv
module lrc_dir_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic        inv_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_alloc, rsp_no_victim;
    logic [4:0]  rsp_set, rsp_way;
    logic [21:0] rsp_tag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    lrc_dir u_lrc_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .inv_all(inv_all), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_alloc(rsp_alloc), .rsp_no_victim(rsp_no_victim),
        .rsp_set(rsp_set), .rsp_way(rsp_way), .rsp_tag(rsp_tag)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic        hit;
        logic        alloc;
        logic [4:0]  way;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0000_0000, 1'b0, 1'b1, 5'd0},
        '{2'd0, 32'h0000_0004, 1'b1, 1'b0, 5'd0},
        '{2'd0, 32'h0000_0400, 1'b0, 1'b1, 5'd1},
        '{2'd0, 32'h0000_0020, 1'b0, 1'b1, 5'd0},
        '{2'd1, 32'h0000_0800, 1'b0, 1'b1, 5'd2},
        '{2'd0, 32'h0000_001C, 1'b1, 1'b0, 5'd0},
        '{2'd1, 32'h0000_0400, 1'b1, 1'b0, 5'd1},
        '{2'd0, 32'h0000_0C00, 1'b0, 1'b1, 5'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input logic inv);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        inv_all   = inv;
        @(negedge clk);
        req_valid = 1'b0;
        inv_all   = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic alloc,
                              input logic nov, input logic [4:0] way);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " hit"}, 32'(rsp_hit), 32'(hit));
        check({req, " alloc"}, 32'(rsp_alloc), 32'(alloc));
        check({req, " no_victim"}, 32'(rsp_no_victim), 32'(nov));
        if (hit || alloc) check({req, " way"}, 32'(rsp_way), 32'(way));
    endtask

    function automatic logic [31:0] s5(input int t);
        return 32'h0000_00A0 + (32'(t) << 10);
    endfunction

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R10 rsp_way after reset", 32'(rsp_way), 32'd0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R6
        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].op, VECS[i].addr, 1'b0);
            expect_rsp("R2 R3 R6 vector", VECS[i].hit, VECS[i].alloc, 1'b0, VECS[i].way);
            check("R1 set field", 32'(rsp_set), 32'(VECS[i].addr[9:5]));
            check("R1 tag field", 32'(rsp_tag), 32'(VECS[i].addr[31:10]));
        end

        // R1 64-byte object spans two neighbouring sets
        do_req(2'd0, 32'h0000_1040, 1'b0);
        check("R1 object first set", 32'(rsp_set), 32'd2);
        do_req(2'd0, 32'h0000_1060, 1'b0);
        check("R1 object second set", 32'(rsp_set), 32'd3);

        // R4 hits do not move the pointer of set 1 (pointer at 1)
        do_req(2'd0, 32'h0000_0020, 1'b0);
        expect_rsp("R4 hit", 1'b1, 1'b0, 1'b0, 5'd0);
        do_req(2'd0, 32'h0000_0024, 1'b0);
        expect_rsp("R4 hit again", 1'b1, 1'b0, 1'b0, 5'd0);
        do_req(2'd0, 32'h0000_0420, 1'b0);
        expect_rsp("R4 miss after hits", 1'b0, 1'b1, 1'b0, 5'd1);

        // R4 fill set 0 up to way 31, then wrap
        for (int t = 4; t < 32; t++) begin
            do_req(2'd0, 32'(t) << 10, 1'b0);
            expect_rsp("R4 fill", 1'b0, 1'b1, 1'b0, 5'(t));
        end
        do_req(2'd0, 32'h0000_8000, 1'b0);
        expect_rsp("R4 wrap to way 0", 1'b0, 1'b1, 1'b0, 5'd0);
        // R5 skip locked ways 1 and 2
        do_req(2'd0, 32'h0000_8400, 1'b0);
        expect_rsp("R5 skip locked", 1'b0, 1'b1, 1'b0, 5'd3);
        do_req(2'd0, 32'h0000_0400, 1'b0);
        expect_rsp("R5 locked survives", 1'b1, 1'b0, 1'b0, 5'd1);
        do_req(2'd0, 32'h0000_0800, 1'b0);
        expect_rsp("R5 locked survives 2", 1'b1, 1'b0, 1'b0, 5'd2);
        do_req(2'd0, 32'h0000_0000, 1'b0);
        expect_rsp("R5 unlocked evicted", 1'b0, 1'b1, 1'b0, 5'd4);

        // R9 invalidate with concurrent request
        do_req(2'd0, 32'h0000_8000, 1'b1);
        check("R9 request dropped", 32'(rsp_valid), 32'd0);
        do_req(2'd0, 32'h0000_0400, 1'b0);
        expect_rsp("R9 locked kept", 1'b1, 1'b0, 1'b0, 5'd1);
        do_req(2'd0, 32'h0000_8000, 1'b0);
        expect_rsp("R9 unlocked cleared", 1'b0, 1'b1, 1'b0, 5'd5);

        // R7 unlock then invalidate
        do_req(2'd2, 32'h0000_0800, 1'b0);
        expect_rsp("R7 unlock hit", 1'b1, 1'b0, 1'b0, 5'd2);
        do_req(2'd2, 32'h0001_F000, 1'b0);
        expect_rsp("R7 unlock miss", 1'b0, 1'b0, 1'b0, 5'd0);
        do_req(2'd0, 32'h0000_0000, 1'b1);
        do_req(2'd0, 32'h0000_0800, 1'b0);
        expect_rsp("R7 unlocked line evictable", 1'b0, 1'b1, 1'b0, 5'd6);

        // R8 lock every way of set 5
        for (int t = 0; t < 32; t++) begin
            do_req(2'd1, s5(t), 1'b0);
            expect_rsp("R6 lock alloc", 1'b0, 1'b1, 1'b0, 5'(t));
        end
        do_req(2'd0, s5(40), 1'b0);
        expect_rsp("R8 full set lookup", 1'b0, 1'b0, 1'b1, 5'd0);
        do_req(2'd1, s5(41), 1'b0);
        expect_rsp("R8 full set lock", 1'b0, 1'b0, 1'b1, 5'd0);
        do_req(2'd0, s5(0), 1'b0);
        expect_rsp("R8 unchanged", 1'b1, 1'b0, 1'b0, 5'd0);
        do_req(2'd2, s5(7), 1'b0);
        expect_rsp("R7 unlock in full set", 1'b1, 1'b0, 1'b0, 5'd7);
        do_req(2'd0, s5(40), 1'b0);
        expect_rsp("R7 R5 freed way used", 1'b0, 1'b1, 1'b0, 5'd7);

        // R11 reserved op
        do_req(2'd3, s5(42), 1'b0);
        check("R11 no response", 32'(rsp_valid), 32'd0);
        do_req(2'd0, s5(40), 1'b0);
        expect_rsp("R11 state unchanged", 1'b1, 1'b0, 1'b0, 5'd7);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 outputs cleared", 32'({rsp_valid, rsp_hit, rsp_alloc}), 32'd0);
        rst_n = 1'b1;
        do_req(2'd0, 32'h0000_0400, 1'b0);
        expect_rsp("R10 lock and pointer cleared", 1'b0, 1'b1, 1'b0, 5'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule